// File: doc/BRIEF.md
# Hierarchical LRU Way Selector with Line Locking

This block holds the replacement state for an 8-way set-associative cache with 32 sets, and names the way to evict in any set. Each set keeps 10 bits of recency state. The eight ways are grouped into four pairs: {0,1}, {2,3}, {4,5} and {6,7}. Six bits record which pair of each of the six pair-to-pair comparisons was used more recently. Four more bits, one per pair, mark the member of that pair that should go next. Every hit or fill is presented as an access strobe with a set and a way, and updates that set's state on the next clock edge.

Software can lock individual lines, one way of one set at a time, and can unlock them again. A locked line is never offered as a victim. No set may hold more than four locked ways. A lock request that would create a fifth is refused and raises an error flag for one cycle. The victim output is combinational in the queried set. It reflects every access and lock change applied up to the last clock edge.

Top module: `hlru_way_sel`

## Requirements
- R1: After synchronous reset every set has no locked ways. Its recency order is pair 0 least recent, then pair 1, then pair 2, with pair 3 most recent, and each pair prefers its even member. The victim of every set is therefore way 0, and `lock_err` is 0.
- R2: An access to way w of set s makes the pair of w (w[2:1]) the most recent pair of s from the next cycle on. That pair is then not the victim of s.
- R3: A set never holds more than four locked ways.
- R4: The victim way of the queried set is never a locked way.
- R5: The victim is chosen from the least recent pair that still has at least one unlocked way. Within that pair it is the member marked as less recent, or the other member if the marked one is locked.
- R6: A lock request (`lock_valid`=1, `lock_on`=1) for an unlocked way in a set that already holds four locked ways is refused. `lock_err` is 1 in the cycle after the request and 0 otherwise, and the lock state of the set is unchanged.
- R7: An unlock request (`lock_on`=0) always clears the named way's lock. A lock request for a way that is already locked is accepted without error and changes nothing.
- R8: An access to a way sets its pair's member mark to the other member of that pair. When the pair next becomes the victim pair and both members are unlocked, the other member is chosen.
- R9: An access or lock request to one set leaves the recency state, locks and victim of every other set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | Access strobe (hit or fill) |
| acc_set | input | 5 | Set index of the access |
| acc_way | input | 3 | Way number of the access |
| lock_valid | input | 1 | Lock or unlock request strobe |
| lock_set | input | 5 | Set index of the lock request |
| lock_way | input | 3 | Way number of the lock request |
| lock_on | input | 1 | 1 = lock the way, 0 = unlock it |
| vq_set | input | 5 | Set whose victim is queried |
| victim_way | output | 3 | Victim way of `vq_set` |
| lock_err | output | 1 | One-cycle flag for a refused lock request |

## Verification
The bench concentrates on pairs with exactly one locked member. A selector that ignored the member lock would hand back a locked line here. It also targets pairs with both members locked; a design that failed to skip such a pair would evict a protected way. The fifth lock request in a full set is checked for a one-cycle error and for no state change. A design that counted incorrectly would either lock a fifth line or refuse a legal fourth one. Repeated locks of an already locked way must not raise the error, and accesses must move only their own pair to the most recent position. An update that mixed up the direction of the pairwise bits would evict the line just used.

// File: rtl/hlru_pkg.sv
package hlru_pkg;

    localparam int WAYS   = 8;
    localparam int PAIRS  = WAYS / 2;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int PAIR_W = $clog2(PAIRS);
    localparam int ORD_W  = PAIRS * (PAIRS - 1) / 2;

    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [PAIR_W-1:0] pair_t;
    typedef logic [WAYS-1:0]   lock_mask_t;

    // ord: one bit per pair comparison (lo<hi), 1 = pair lo used more recently
    // pbit: one bit per pair, 1 = odd member is the one to evict next
    typedef struct packed {
        logic [ORD_W-1:0] ord;
        logic [PAIRS-1:0] pbit;
    } repl_state_t;

    localparam repl_state_t REPL_RESET = '0;

    // index of the comparison bit for pairs lo < hi
    function automatic int ord_bit(input int lo, input int hi);
        int base;
        base = 0;
        for (int k = 0; k < lo; k++) begin
            base = base + (PAIRS - 1 - k);
        end
        return base + (hi - lo - 1);
    endfunction

    // 1 when pair a was used less recently than pair b
    function automatic logic pair_older(input logic [ORD_W-1:0] ord,
                                        input int a, input int b);
        if (a < b) begin
            return ~ord[ord_bit(a, b)];
        end
        return ord[ord_bit(b, a)];
    endfunction

    function automatic repl_state_t touch(input repl_state_t s, input way_t w);
        repl_state_t n;
        int p;
        n = s;
        p = int'(w[WAY_W-1:1]);
        for (int lo = 0; lo < PAIRS; lo++) begin
            for (int hi = lo + 1; hi < PAIRS; hi++) begin
                if (lo == p) begin
                    n.ord[ord_bit(lo, hi)] = 1'b1;
                end else if (hi == p) begin
                    n.ord[ord_bit(lo, hi)] = 1'b0;
                end
            end
        end
        n.pbit[p] = ~w[0];
        return n;
    endfunction

    function automatic int lock_count(input lock_mask_t m);
        int c;
        c = 0;
        for (int i = 0; i < WAYS; i++) begin
            c = c + int'(m[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/hlru_repl_store.sv
module hlru_repl_store
    import hlru_pkg::*;
#(
    parameter int NUM_SETS = 32,
    localparam int SET_W = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_en,
    input  logic [SET_W-1:0] upd_set,
    input  way_t             upd_way,
    input  logic [SET_W-1:0] rd_set,
    output repl_state_t      rd_state
);

    repl_state_t st_q [NUM_SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SETS; i++) begin
                st_q[i] <= REPL_RESET;
            end
        end else if (upd_en) begin
            st_q[upd_set] <= touch(st_q[upd_set], upd_way);
        end
    end

    assign rd_state = st_q[rd_set];

endmodule

// File: rtl/hlru_lock_table.sv
module hlru_lock_table
    import hlru_pkg::*;
#(
    parameter int NUM_SETS   = 32,
    parameter int MAX_LOCKED = 4,
    localparam int SET_W = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [SET_W-1:0] req_set,
    input  way_t             req_way,
    input  logic             req_lock,
    input  logic [SET_W-1:0] qry_set,
    output lock_mask_t       qry_mask,
    output lock_mask_t       req_mask,
    output logic             err
);

    lock_mask_t lk_q [NUM_SETS];
    logic       full;
    logic       refuse;
    lock_mask_t next_mask;

    assign req_mask = lk_q[req_set];
    assign qry_mask = lk_q[qry_set];
    assign full     = lock_count(req_mask) >= MAX_LOCKED;
    assign refuse   = req_valid && req_lock && !req_mask[req_way] && full;

    always_comb begin
        next_mask = req_mask;
        next_mask[req_way] = req_lock;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SETS; i++) begin
                lk_q[i] <= '0;
            end
            err <= 1'b0;
        end else begin
            err <= refuse;
            if (req_valid && !refuse) begin
                lk_q[req_set] <= next_mask;
            end
        end
    end

endmodule

// File: rtl/hlru_victim_pick.sv
module hlru_victim_pick
    import hlru_pkg::*;
(
    input  repl_state_t st,
    input  lock_mask_t  lock,
    output way_t        victim
);

    logic [PAIRS-1:0] usable;
    logic [PAIRS-1:0] is_lru;
    logic [PAIRS-1:0] member;

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        logic pref;
        assign usable[p] = ~(lock[2*p] & lock[2*p+1]);
        assign pref      = st.pbit[p];
        assign member[p] = lock[{pair_t'(p), pref}] ? ~pref : pref;

        always_comb begin
            is_lru[p] = usable[p];
            for (int q = 0; q < PAIRS; q++) begin
                if (q != p && usable[q] && !pair_older(st.ord, p, q)) begin
                    is_lru[p] = 1'b0;
                end
            end
        end
    end

    always_comb begin
        victim = '0;
        for (int p = 0; p < PAIRS; p++) begin
            if (is_lru[p]) begin
                victim = {pair_t'(p), member[p]};
            end
        end
    end

endmodule

// File: rtl/hlru_way_sel.sv
module hlru_way_sel
    import hlru_pkg::*;
#(
    parameter int NUM_SETS   = 32,
    parameter int MAX_LOCKED = 4,
    localparam int SET_W = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic [SET_W-1:0] acc_set,
    input  logic [2:0]       acc_way,
    input  logic             lock_valid,
    input  logic [SET_W-1:0] lock_set,
    input  logic [2:0]       lock_way,
    input  logic             lock_on,
    input  logic [SET_W-1:0] vq_set,
    output logic [2:0]       victim_way,
    output logic             lock_err
);

    repl_state_t q_state;
    lock_mask_t  q_lock;
    lock_mask_t  l_lock;

    hlru_repl_store #(.NUM_SETS(NUM_SETS)) u_store (
        .clk      (clk),
        .rst      (rst),
        .upd_en   (acc_valid),
        .upd_set  (acc_set),
        .upd_way  (acc_way),
        .rd_set   (vq_set),
        .rd_state (q_state)
    );

    hlru_lock_table #(.NUM_SETS(NUM_SETS), .MAX_LOCKED(MAX_LOCKED)) u_locks (
        .clk       (clk),
        .rst       (rst),
        .req_valid (lock_valid),
        .req_set   (lock_set),
        .req_way   (lock_way),
        .req_lock  (lock_on),
        .qry_set   (vq_set),
        .qry_mask  (q_lock),
        .req_mask  (l_lock),
        .err       (lock_err)
    );

    hlru_victim_pick u_pick (
        .st     (q_state),
        .lock   (q_lock),
        .victim (victim_way)
    );

endmodule

// File: rtl/hlru_way_sel_chk.sv
module hlru_way_sel_chk #(
    parameter int NUM_SETS   = 32,
    parameter int MAX_LOCKED = 4,
    localparam int SET_W = $clog2(NUM_SETS)
) (
    input logic             clk,
    input logic             rst,
    input logic             acc_valid,
    input logic [SET_W-1:0] acc_set,
    input logic [2:0]       acc_way,
    input logic             lock_valid,
    input logic [2:0]       lock_way,
    input logic             lock_on,
    input logic [SET_W-1:0] vq_set,
    input logic [2:0]       victim_way,
    input logic             lock_err,
    input logic [7:0]       q_lock,
    input logic [7:0]       l_lock
);

    AST_VICTIM_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
        !q_lock[victim_way]); // R4

    AST_LOCK_CAP: assert property (@(posedge clk) disable iff (rst)
        $countones(q_lock) <= MAX_LOCKED); // R3

    AST_FULL_SET_ERR: assert property (@(posedge clk) disable iff (rst)
        (lock_valid && lock_on && !l_lock[lock_way] && $countones(l_lock) >= MAX_LOCKED)
        |=> lock_err); // R6

    AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        lock_err |-> $past(lock_valid && lock_on)); // R6

    AST_MRU_SPARED: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> (vq_set != $past(acc_set)) || (victim_way[2:1] != $past(acc_way[2:1]))); // R2

endmodule

bind hlru_way_sel hlru_way_sel_chk #(.NUM_SETS(NUM_SETS), .MAX_LOCKED(MAX_LOCKED)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_set    (acc_set),
    .acc_way    (acc_way),
    .lock_valid (lock_valid),
    .lock_way   (lock_way),
    .lock_on    (lock_on),
    .vq_set     (vq_set),
    .victim_way (victim_way),
    .lock_err   (lock_err),
    .q_lock     (q_lock),
    .l_lock     (l_lock)
);

// File: tb/test_hlru_way_sel.sv
`timescale 1ns/1ps
module test_hlru_way_sel;

    localparam int NS = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       acc_valid = 1'b0;
    logic [4:0] acc_set = '0;
    logic [2:0] acc_way = '0;
    logic       lock_valid = 1'b0;
    logic [4:0] lock_set = '0;
    logic [2:0] lock_way = '0;
    logic       lock_on = 1'b0;
    logic [4:0] vq_set = '0;
    logic [2:0] victim_way;
    logic       lock_err;

    int n_chk = 0;
    int n_bad = 0;

    // reference model: recency list per set, index 0 = least recent pair
    int   ord_m [NS][4];
    logic pb_m  [NS][4];
    logic [7:0] lk_m [NS];
    logic exp_err = 1'b0;

    always #2 clk = ~clk;

    hlru_way_sel i_hlru_way_sel (
        .clk, .rst, .acc_valid, .acc_set, .acc_way,
        .lock_valid, .lock_set, .lock_way, .lock_on,
        .vq_set, .victim_way, .lock_err
    );

    function automatic logic [2:0] model_victim(input int s);
        for (int i = 0; i < 4; i++) begin
            int p;
            int m;
            p = ord_m[s][i];
            if (!(lk_m[s][2*p] && lk_m[s][2*p+1])) begin
                m = pb_m[s][p] ? 1 : 0;
                if (lk_m[s][2*p+m]) m = 1 - m;
                return 3'(2*p + m);
            end
        end
        return 3'd0;
    endfunction

    function automatic int popc(input logic [7:0] m);
        int c;
        c = 0;
        for (int i = 0; i < 8; i++) c += int'(m[i]);
        return c;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < NS; s++) begin
            for (int p = 0; p < 4; p++) begin
                ord_m[s][p] = p;
                pb_m[s][p]  = 1'b0;
            end
            lk_m[s] = '0;
        end
        exp_err = 1'b0;
    endtask

    // drive at negedge, model the coming edge, check at the following negedge
    task automatic step(input logic av, input int as, input int aw,
                        input logic lv, input int ls, input int lw, input logic lo,
                        input int qs, input string tag);
        acc_valid = av; acc_set = 5'(as); acc_way = 3'(aw);
        lock_valid = lv; lock_set = 5'(ls); lock_way = 3'(lw); lock_on = lo;
        vq_set = 5'(qs);
        exp_err = 1'b0;
        if (av) begin
            int p;
            int k;
            p = aw / 2;
            k = 0;
            for (int i = 0; i < 4; i++) if (ord_m[as][i] == p) k = i;
            for (int i = k; i < 3; i++) ord_m[as][i] = ord_m[as][i+1];
            ord_m[as][3] = p;
            pb_m[as][p] = (aw % 2 == 0);
        end
        if (lv) begin
            if (!lo) begin
                lk_m[ls][lw] = 1'b0;
            end else if (!lk_m[ls][lw]) begin
                if (popc(lk_m[ls]) >= 4) exp_err = 1'b1;
                else lk_m[ls][lw] = 1'b1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, int'(victim_way), int'(model_victim(qs)));
        check("R6", int'(lock_err), int'(exp_err));
    endtask

    task automatic idle_q(input int qs, input string tag);
        step(1'b0, 0, 0, 1'b0, 0, 0, 1'b0, qs, tag);
    endtask

    task automatic run_all();
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state of every set
        for (int s = 0; s < NS; s++) begin
            vq_set = 5'(s);
            #0.5;
            check("R1", int'(victim_way), 0);
        end
        check("R1", int'(lock_err), 0);

        // R2 / R9
        step(1'b1, 5, 0, 1'b0, 0, 0, 1'b0, 5, "R2");
        check("R2", int'(victim_way), 2);
        idle_q(6, "R9");
        check("R9", int'(victim_way), 0);
        step(1'b1, 5, 2, 1'b0, 0, 0, 1'b0, 5, "R2");
        check("R2", int'(victim_way), 4);

        // R8: pair 0 touched at way 0, then ages back to least recent
        step(1'b1, 7, 0, 1'b0, 0, 0, 1'b0, 7, "R8");
        step(1'b1, 7, 2, 1'b0, 0, 0, 1'b0, 7, "R8");
        step(1'b1, 7, 4, 1'b0, 0, 0, 1'b0, 7, "R8");
        step(1'b1, 7, 6, 1'b0, 0, 0, 1'b0, 7, "R8");
        check("R8", int'(victim_way), 1);

        // R4 / R5: single-member lock, then whole pair locked
        step(1'b0, 0, 0, 1'b1, 8, 0, 1'b1, 8, "R4");
        check("R4", int'(victim_way), 1);
        step(1'b0, 0, 0, 1'b1, 8, 1, 1'b1, 8, "R5");
        check("R5", int'(victim_way), 2);
        step(1'b0, 0, 0, 1'b1, 8, 2, 1'b1, 8, "R5");
        step(1'b0, 0, 0, 1'b1, 8, 3, 1'b1, 8, "R5");
        check("R5", int'(victim_way), 4);

        // R3 / R6: fifth lock refused, no change
        step(1'b0, 0, 0, 1'b1, 8, 4, 1'b1, 8, "R3");
        check("R6", int'(lock_err), 1);
        check("R3", int'(victim_way), 4);
        idle_q(8, "R6");
        check("R6", int'(lock_err), 0);

        // R7: relock of a locked way, then unlock
        step(1'b0, 0, 0, 1'b1, 8, 3, 1'b1, 8, "R7");
        check("R7", int'(lock_err), 0);
        step(1'b0, 0, 0, 1'b1, 8, 0, 1'b0, 8, "R7");
        check("R7", int'(victim_way), 0);
        idle_q(9, "R9");
        check("R9", int'(victim_way), 0);

        // constrained random mix
        for (int n = 0; n < 4000; n++) begin
            logic av;
            logic lv;
            logic lo;
            av = ($urandom % 2) == 0;
            lv = ($urandom % 10) < 4;
            lo = ($urandom % 10) < 7;
            step(av, int'($urandom % NS), int'($urandom % 8),
                 lv, int'($urandom % NS), int'($urandom % 8), lo,
                 int'($urandom % NS), "R5");
        end
        acc_valid = 1'b0;
        lock_valid = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule